// File: doc/BRIEF.md
# Burst PSRAM Access Engine

This block is the device side of a synchronous burst memory. A controller starts a burst by pulling the select and address-strobe inputs low on one clock edge. The engine captures the start address and the direction at that edge. It holds its wait output high through a fixed initial latency and then moves one 16-bit word per clock through an internal word array. Reads present the addressed word on the data output. Writes capture the data input, and two active-low lane enables mask the low and high bytes.

The array is divided into rows of a parameterised number of words. Leaving the last word of a row costs one wait cycle. A continuous burst that runs past the top address carries on from address zero. A hidden refresh engine takes refresh requests and runs each one for a parameterised number of cycles, but it only starts while no burst is in progress. A burst that is captured while a refresh is still running holds its latency count until that refresh is over. The wait-mode input selects the wait timing. In one setting the wait output tracks the current cycle. In the other it leads the data by one clock, so the controller sees ahead of time that the next cycle carries valid data.

Top module: `psram_burst_engine`

## Requirements
- R1: After reset the wait output and the data-out enable are low and no burst is active.
- R2: A clock edge with chip_sel_n low and addr_vld_n low captures addr as the start address and write_n (0 = write, 1 = read) as the direction. Any burst already running is abandoned.
- R3: If no refresh is running, exactly INIT_LAT wait cycles follow the capture edge before the first word.
- R4: Once wait is low, one word transfers per clock at consecutive addresses. A read drives the stored word on rdata. A write stores wdata at the edge that ends the cycle.
- R5: After the word whose low log2(ROW_WORDS) address bits are all ones, exactly one wait cycle is inserted before the next word.
- R6: After the highest address, the burst continues at address 0.
- R7: byte_lo_n high keeps bits 7:0 of the written word unchanged, and byte_hi_n high keeps bits 15:8 unchanged. With both high nothing is written, but the burst keeps its normal timing.
- R8: rdata_oe is high only in read transfer cycles with out_en_n low, chip_sel_n low and at least one lane enable low.
- R9: While a refresh is running, a burst in its latency phase holds its count. Its wait length is the number of refresh cycles still remaining after the capture edge, plus INIT_LAT.
- R10: A refresh request that arrives during a burst does not disturb that burst. It is held and starts at the first edge with no burst active, and it runs REF_CYCLES cycles.
- R11: With wait_early = 0, wait_o is low exactly in transfer cycles. With wait_early = 1, wait_o in each cycle equals the wait_early = 0 value of the next cycle.
- R12: An edge with chip_sel_n high ends any burst, and wait_o and rdata_oe then stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Active-low device select |
| addr_vld_n | input | 1 | Active-low start-address strobe |
| out_en_n | input | 1 | Active-low output enable |
| write_n | input | 1 | Direction captured at start, 0 = write |
| byte_lo_n | input | 1 | Active-low enable for bits 7:0 |
| byte_hi_n | input | 1 | Active-low enable for bits 15:8 |
| addr | input | ADDR_W | Burst start word address |
| wdata | input | 16 | Write data |
| refresh_req | input | 1 | Hidden-refresh request pulse |
| wait_early | input | 1 | 1 = wait leads data by one cycle |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Read data drive enable |
| wait_o | output | 1 | Wait indication |

## Verification
The main function is exercised by write-then-read burst pairs of several kinds. Some start mid-row and stay inside the row; these isolate the plain initial latency. Some cross a row end; these expose the single boundary stall. One runs through the top address, which separates correct wrap-around from running off the array. Others write with only one lane, or with no lane, enabled, which shows per-byte masking against full overwrite. Directed bursts then run in three situations: against a refresh already running, which tests the held latency count; with a refresh requested mid-burst, which must be deferred and must then collide with the next burst; and with the leading wait mode, where each cycle's wait must predict the next cycle's data drive.

// File: rtl/psram_burst_pkg.sv
`timescale 1ns/1ps
package psram_burst_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_XFER = 2'd2,
    ST_BND  = 2'd3
  } burst_st_e;
endpackage

// File: rtl/psram_refresh_ctl.sv
`timescale 1ns/1ps
module psram_refresh_ctl #(
  parameter int REF_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic idle,
  output logic busy
);
  localparam int RW = $clog2(REF_CYCLES + 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          go;

  assign busy = (cnt_q != '0);
  assign go   = (pend_q || req) && idle && !busy;

  always_comb begin
    pend_d = pend_q || req;
    cnt_d  = cnt_q;
    if (busy) begin
      cnt_d = cnt_q - RW'(1);
    end else if (go) begin
      cnt_d  = RW'(REF_CYCLES);
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  // R10
  refresh_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(idle));
endmodule

// File: rtl/psram_word_array.sv
`timescale 1ns/1ps
module psram_word_array
  import psram_burst_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  be,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && be[g]) begin
        lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
  end

  // R7
  lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (be != '0));
endmodule

// File: rtl/psram_burst_fsm.sv
`timescale 1ns/1ps
module psram_burst_fsm
  import psram_burst_pkg::*;
#(
  parameter int AW        = 10,
  parameter int ROW_WORDS = 128,
  parameter int INIT_LAT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          adv_n,
  input  logic          dir_n,
  input  logic [AW-1:0] start_addr,
  input  logic          ref_busy,
  input  logic          wait_early,
  output logic [AW-1:0] ptr,
  output logic          xfer,
  output logic          is_wr,
  output logic          idle,
  output logic          wait_o
);
  localparam int RB = $clog2(ROW_WORDS);
  localparam int LW = $clog2(INIT_LAT + 1);

  burst_st_e     st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          wr_q, wr_d;
  logic          start, row_last, ptr_en;
  logic          wait_now, wait_nxt;

  assign start    = !sel_n && !adv_n;
  assign row_last = &ptr_q[RB-1:0];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    wr_d   = wr_q;
    ptr_en = 1'b0;
    if (sel_n) begin
      st_d = ST_IDLE;
    end else if (start) begin
      st_d   = ST_LAT;
      cnt_d  = LW'(INIT_LAT);
      ptr_d  = start_addr;
      ptr_en = 1'b1;
      wr_d   = !dir_n;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_LAT: begin
          if (!ref_busy) begin
            if (cnt_q == LW'(1)) st_d = ST_XFER;
            else                 cnt_d = cnt_q - LW'(1);
          end
        end
        ST_XFER: begin
          ptr_d  = ptr_q + AW'(1);
          ptr_en = 1'b1;
          st_d   = row_last ? ST_BND : ST_XFER;
        end
        ST_BND:  st_d = ST_XFER;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign wait_now = (st_q == ST_LAT) || (st_q == ST_BND);
  assign wait_nxt = (st_d == ST_LAT) || (st_d == ST_BND);
  assign wait_o   = wait_early ? wait_nxt : wait_now;
  assign ptr      = ptr_q;
  assign xfer     = (st_q == ST_XFER);
  assign is_wr    = wr_q;
  assign idle     = (st_q == ST_IDLE);

  // R2
  start_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !adv_n) |=> (st_q == ST_LAT && ptr_q == $past(start_addr)));
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER && !sel_n && adv_n) |=> (ptr_q == $past(ptr_q) + AW'(1)));
  // R5
  row_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BND) |-> ($past(st_q) == ST_XFER && ptr_q[RB-1:0] == '0));
  // R9
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAT && ref_busy && !sel_n && adv_n) |=> (st_q == ST_LAT && cnt_q == $past(cnt_q)));
  // R12
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (st_q == ST_IDLE && !wait_now));
endmodule

// File: rtl/psram_burst_engine.sv
`timescale 1ns/1ps
module psram_burst_engine
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int ROW_WORDS  = 128,
  parameter int INIT_LAT   = 4,
  parameter int REF_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_sel_n,
  input  logic              addr_vld_n,
  input  logic              out_en_n,
  input  logic              write_n,
  input  logic              byte_lo_n,
  input  logic              byte_hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              refresh_req,
  input  logic              wait_early,
  output logic [15:0]       rdata,
  output logic              rdata_oe,
  output logic              wait_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] ptr;
  logic              xfer, is_wr, idle, ref_busy;
  logic [LANES-1:0]  be;
  logic              lanes_on, mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign be       = {!byte_hi_n, !byte_lo_n};
  assign lanes_on = |be;
  assign mem_we   = xfer && is_wr && !chip_sel_n && addr_vld_n && lanes_on;
  assign rdata_oe = xfer && !is_wr && !chip_sel_n && !out_en_n && lanes_on;

  psram_refresh_ctl #(.REF_CYCLES(REF_CYCLES)) u_ref (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (refresh_req),
    .idle  (idle),
    .busy  (ref_busy)
  );

  psram_burst_fsm #(
    .AW        (ADDR_W),
    .ROW_WORDS (ROW_WORDS),
    .INIT_LAT  (INIT_LAT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sel_n      (chip_sel_n),
    .adv_n      (addr_vld_n),
    .dir_n      (write_n),
    .start_addr (addr),
    .ref_busy   (ref_busy),
    .wait_early (wait_early),
    .ptr        (ptr),
    .xfer       (xfer),
    .is_wr      (is_wr),
    .idle       (idle),
    .wait_o     (wait_o)
  );

  psram_word_array #(.AW(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (mem_we),
    .be    (be),
    .addr  (ptr),
    .wdata (wdata),
    .rdata (rdata)
  );

  // R8
  oe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rdata_oe |-> (!is_wr && !wait_o | wait_early));
endmodule

// File: tb/sim_psram_burst_engine.sv
`timescale 1ns/1ps
module sim_psram_burst_engine;
  localparam int AW_C  = 6;
  localparam int ROW_C = 8;
  localparam int LAT_C = 3;
  localparam int REF_C = 4;

  // {addr[39:32], len[31:24], 6'b0, lo_n[17], hi_n[16], seed[15:0]}
  localparam logic [39:0] VEC [6] = '{
    {8'h02, 8'd5, 6'd0, 1'b0, 1'b0, 16'h1111},
    {8'h05, 8'd6, 6'd0, 1'b0, 1'b0, 16'h2222},
    {8'h03, 8'd3, 6'd0, 1'b0, 1'b1, 16'hA5A5},
    {8'h3D, 8'd6, 6'd0, 1'b0, 1'b0, 16'h4444},
    {8'h3E, 8'd3, 6'd0, 1'b1, 1'b0, 16'h5A00},
    {8'h04, 8'd2, 6'd0, 1'b1, 1'b1, 16'hFFFF}
  };

  logic            clk, rst_n;
  logic            chip_sel_n, addr_vld_n, out_en_n, write_n, byte_lo_n, byte_hi_n;
  logic [AW_C-1:0] addr;
  logic [15:0]     wdata, rdata;
  logic            refresh_req, wait_early, rdata_oe, wait_o;
  logic [15:0]     model [64];
  int              n_chk = 0, n_bad = 0;
  bit              done = 0;

  psram_burst_engine #(
    .ADDR_W(AW_C), .ROW_WORDS(ROW_C), .INIT_LAT(LAT_C), .REF_CYCLES(REF_C)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .addr_vld_n(addr_vld_n),
    .out_en_n(out_en_n), .write_n(write_n), .byte_lo_n(byte_lo_n), .byte_hi_n(byte_hi_n),
    .addr(addr), .wdata(wdata), .refresh_req(refresh_req), .wait_early(wait_early),
    .rdata(rdata), .rdata_oe(rdata_oe), .wait_o(wait_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_stalls(input logic [AW_C-1:0] a, input int n);
    int s = 0;
    for (int i = 0; i < n - 1; i++)
      if (((int'(a) + i) % ROW_C) == ROW_C - 1) s++;
    return s;
  endfunction

  // Called at a negedge, returns at a negedge with the bus idle.
  task automatic run_burst(input bit wr, input logic [AW_C-1:0] a, input int n,
                           input bit lon, input bit hin, input logic [15:0] seed,
                           input int ref_at, input bit early,
                           output int fw, output int mw);
    int k = 0, cyc = 0;
    bit valid, prev_w, oe_s, w_s;
    logic [AW_C-1:0] wa;
    logic [15:0] v;
    fw = 0; mw = 0;
    chip_sel_n = 0; addr_vld_n = 0; write_n = !wr; out_en_n = wr;
    byte_lo_n = lon; byte_hi_n = hin; addr = a;
    #1 prev_w = wait_o;
    @(negedge clk);
    while (k < n && cyc < 200) begin
      addr_vld_n = 1; refresh_req = (cyc == ref_at);
      #1;
      w_s = wait_o; oe_s = rdata_oe;
      valid = early ? oe_s : !w_s;
      if (!wr) begin
        if (early)             check("R11 wait leads data", 32'(prev_w), 32'(!oe_s));
        else if (!(lon && hin)) check("R11 wait vs data", 32'(w_s), 32'(!oe_s));
        if (lon && hin)        check("R8 bus off with both lanes off", 32'(oe_s), 0);
      end
      prev_w = w_s;
      if (!valid) begin
        if (k == 0) fw++; else mw++;
      end else begin
        wa = a + AW_C'(k);
        v  = seed + 16'(k) * 16'h0111;
        if (wr) begin
          wdata = v;
          if (!lon) model[wa][7:0]  = v[7:0];
          if (!hin) model[wa][15:8] = v[15:8];
        end else if (!(lon && hin)) begin
          check("R2 R4 R6 R7 read word", 32'(rdata), 32'(model[wa]));
        end
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    chip_sel_n = 1; addr_vld_n = 1; write_n = 1; out_en_n = 1;
    refresh_req = 0; byte_lo_n = 0; byte_hi_n = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int fw, mw;
    logic [AW_C-1:0] a;
    int n;
    rst_n = 0; chip_sel_n = 1; addr_vld_n = 1; out_en_n = 1; write_n = 1;
    byte_lo_n = 0; byte_hi_n = 0; addr = '0; wdata = '0; refresh_req = 0; wait_early = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    check("R1 wait after reset", 32'(wait_o), 0);
    check("R1 oe after reset", 32'(rdata_oe), 0);
    @(negedge clk);

    // Table: write burst then read back each vector
    for (int i = 0; i < 6; i++) begin
      a = VEC[i][32 +: AW_C];
      n = int'(VEC[i][31:24]);
      run_burst(1, a, n, VEC[i][17], VEC[i][16], VEC[i][15:0], -1, 0, fw, mw);
      check("R3 write initial wait", 32'(fw), 32'(LAT_C));
      check("R5 write row stalls", 32'(mw), 32'(exp_stalls(a, n)));
      run_burst(0, a, n, 0, 0, 16'h0, -1, 0, fw, mw);
      check("R3 read initial wait", 32'(fw), 32'(LAT_C));
      check("R5 R6 read row stalls", 32'(mw), 32'(exp_stalls(a, n)));
    end

    // R9 burst captured one edge after a refresh starts
    refresh_req = 1;
    @(negedge clk);
    refresh_req = 0;
    run_burst(0, 6'h02, 2, 0, 0, 16'h0, -1, 0, fw, mw);
    check("R9 collision wait", 32'(fw), 32'(REF_C - 1 + LAT_C));

    // R10 request mid-burst is deferred, then collides with the next burst
    run_burst(0, 6'h08, 3, 0, 0, 16'h0, 4, 0, fw, mw);
    check("R10 burst undisturbed initial", 32'(fw), 32'(LAT_C));
    check("R10 burst undisturbed middle", 32'(mw), 0);
    run_burst(0, 6'h02, 2, 0, 0, 16'h0, -1, 0, fw, mw);
    check("R10 deferred refresh stalls next burst", 32'(fw), 32'(REF_C + LAT_C));

    // R11 leading wait mode across a row boundary
    wait_early = 1;
    run_burst(0, 6'h06, 4, 0, 0, 16'h0, -1, 1, fw, mw);
    check("R11 early mode latency", 32'(fw), 32'(LAT_C));
    check("R11 early mode boundary", 32'(mw), 1);
    wait_early = 0;

    // R7 R8 read with both lanes off keeps timing but does not drive
    run_burst(0, 6'h02, 2, 1, 1, 16'h0, -1, 0, fw, mw);
    check("R7 inactive lanes keep timing", 32'(fw), 32'(LAT_C));

    // R12 deselect during latency
    chip_sel_n = 0; addr_vld_n = 0; write_n = 1; out_en_n = 0; addr = 6'h02;
    @(negedge clk);
    addr_vld_n = 1;
    #1 check("R3 wait during latency", 32'(wait_o), 1);
    chip_sel_n = 1;
    @(negedge clk);
    #1;
    check("R12 wait after deselect", 32'(wait_o), 0);
    check("R12 oe after deselect", 32'(rdata_oe), 0);
    out_en_n = 1;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule